// File: doc/BRIEF.md
# Multithreaded Reorder Buffer with Walking Squash

This block tracks in-flight instructions for up to four hardware threads in program order. Each thread owns an in-order queue of tags: a sequence number plus a ready flag and a squashed flag. All threads draw on one shared budget of entries. A selectable capacity policy sets how many entries each thread may hold. The front end inserts tags when `ins_ready` is high. Execution marks tags ready by sequence number. The commit stage retires the oldest tag of a thread once that tag is ready.

A mispredict or fault raises a squash for one thread with a boundary sequence number. The block then walks that thread's queue backward from its youngest entry. It visits at most `SQW` entries per cycle. Every entry younger than the boundary is flagged squashed and ready, so it leaves through the normal retire path. The block also reports free space per thread and in total, the oldest head and youngest tail across the active threads, and whether any active thread can commit.

Top module: `rob_mt`

## Requirements
- R1: After a synchronous active-low reset, all queues are empty. `free_total` equals DEPTH (32), `head_valid`, `tail_valid`, `can_commit` and `ins_err` are 0, and every `sq_busy` bit is 0.
- R2: Policy code 0 (dynamic; code 3 behaves the same) gives each thread slot below `cfg_nthr` a limit of DEPTH. Under every policy, a slot at or above `cfg_nthr` has a limit of 0.
- R3: Policy code 1 (partitioned) gives each configured thread DEPTH divided by the number of active configured threads, rounded down. When no configured thread is active, the divisor is `cfg_nthr`.
- R4: Policy code 2 (threshold) caps each configured thread at THRESH (8). When exactly one configured thread is active, that thread's cap is DEPTH.
- R5: Each thread's field of `free_thr` (6 bits, thread t at bits [6t+5:6t]) is its limit minus its occupancy, floored at 0. `free_total` is DEPTH minus total occupancy. An accepted insert lowers both by one on the next cycle.
- R6: `ins_ready` is low when the pool is full or the addressed thread has no free space. An insert offered while it is low changes nothing and sets `ins_err`, which stays set until reset.
- R7: `head_seq`/`head_tid` name the smallest head sequence number among non-empty active threads, and `tail_seq`/`tail_tid` name the largest tail sequence number. Sequence numbers compare as unsigned values, and ties go to the lower thread id. Both valid flags are 0 when no such thread exists.
- R8: A ready-set request marks every stored entry of the named thread that has the given sequence number. `head_rdy[t]` is 1 only when thread t is non-empty and its oldest entry is ready. `can_commit` is the OR of `head_rdy` over active threads.
- R9: A retire request removes the oldest entry of the named thread only when `head_rdy` of that thread is 1. Otherwise it is ignored.
- R10: A squash request to an empty thread is ignored, and that thread's `sq_busy` stays 0.
- R11: A squash request to a non-empty thread raises `sq_busy` on the next edge. Each later cycle marks at most SQW (2) entries, youngest first, each with a sequence number greater than the boundary. Every marked entry becomes both squashed and ready.
- R12: The walk ends, and `sq_busy` drops, on the edge that reaches an entry whose sequence number is at or below the boundary. It also ends on the edge that marks the thread's oldest entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| policy | input | 2 | Capacity policy: 0 dynamic, 1 partitioned, 2 threshold, 3 dynamic |
| cfg_nthr | input | 3 | Number of configured thread slots |
| active | input | 4 | Active-thread mask |
| ins_valid | input | 1 | Insert request |
| ins_tid | input | 2 | Insert thread |
| ins_seq | input | 16 | Insert sequence number |
| ins_ready | output | 1 | Insert can be accepted |
| ins_err | output | 1 | Sticky: insert was offered while not ready |
| rdy_valid | input | 1 | Ready-set request |
| rdy_tid | input | 2 | Ready-set thread |
| rdy_seq | input | 16 | Sequence number to mark ready |
| ret_valid | input | 1 | Retire request |
| ret_tid | input | 2 | Retire thread |
| sq_valid | input | 1 | Squash request |
| sq_tid | input | 2 | Squash thread |
| sq_seq | input | 16 | Squash boundary sequence number |
| free_total | output | 6 | Free entries in the pool |
| free_thr | output | 24 | Free entries per thread, 6 bits each |
| head_valid | output | 1 | Oldest head exists |
| head_tid | output | 2 | Thread of the oldest head |
| head_seq | output | 16 | Sequence number of the oldest head |
| tail_valid | output | 1 | Youngest tail exists |
| tail_tid | output | 2 | Thread of the youngest tail |
| tail_seq | output | 16 | Sequence number of the youngest tail |
| head_rdy | output | 4 | Per-thread oldest entry ready |
| head_sqd | output | 4 | Per-thread oldest entry squashed |
| can_commit | output | 1 | Some active thread can retire |
| sq_busy | output | 4 | Per-thread squash walk in progress |

## Verification
The capacity limits, free counts, head and tail selection, and the ready flags are computed combinationally from registered state, so they can be read in the same cycle the configuration inputs change. The bench samples them one time unit after the edge that performs an insert, ready-set or retire. A squash takes one edge to register the request, then one edge per group of up to two entries. The bench therefore checks `sq_busy` after the request edge, after the last edge that still marks entries, and on the edge that ends the walk. It then retires entries one at a time to read each entry's flags from the head outputs.

// File: rtl/rob_pkg.sv
// Shared definitions for the multithreaded reorder buffer.
// Assumes: policy codes are decoded only by rob_cap.
package rob_pkg;
    typedef enum logic [1:0] {
        POL_DYN  = 2'd0,
        POL_PART = 2'd1,
        POL_THR  = 2'd2,
        POL_ALT  = 2'd3
    } rob_policy_e;
endpackage

// File: rtl/rob_cap.sv
// Per-thread capacity limit from policy, configured thread count and active mask.
// Assumes: NT small; the divisor is picked from a constant table built by loop.
module rob_cap #(
    parameter int NT     = 4,
    parameter int DEPTH  = 32,
    parameter int THRESH = 8
) (
    input  logic [1:0]                        policy,
    input  logic [$clog2(NT):0]               cfg_nthr,
    input  logic [NT-1:0]                     active,
    output logic [NT-1:0][$clog2(DEPTH):0]    limit
);
    import rob_pkg::*;
    localparam int CW = $clog2(DEPTH) + 1;
    localparam int TW = $clog2(NT) + 1;

    // DEPTH divided by k for k in 1..NT, zero otherwise
    function automatic logic [CW-1:0] share(input logic [TW-1:0] k);
        logic [CW-1:0] q;
        q = '0;
        for (int j = 1; j <= NT; j++)
            if (k == TW'(j)) q = CW'(DEPTH / j);
        return q;
    endfunction

    logic [NT-1:0] cfg_mask;
    logic [NT-1:0] act_cfg;
    logic [TW-1:0] nact;
    rob_policy_e   pol;

    // Configured-slot mask and active count among configured slots
    always_comb begin
        pol  = rob_policy_e'(policy);
        nact = '0;
        for (int t = 0; t < NT; t++) begin
            cfg_mask[t] = (TW'(t) < cfg_nthr);
            act_cfg[t]  = cfg_mask[t] & active[t];
            nact        = nact + TW'(act_cfg[t]);
        end
    end

    // Limit per slot under the selected policy
    always_comb begin
        for (int t = 0; t < NT; t++) begin
            if (!cfg_mask[t])
                limit[t] = '0;
            else if (pol == POL_PART)
                limit[t] = share((nact == '0) ? cfg_nthr : nact);
            else if (pol == POL_THR)
                limit[t] = (nact == TW'(1) && act_cfg[t]) ? CW'(DEPTH) : CW'(THRESH);
            else
                limit[t] = CW'(DEPTH);
        end
    end
endmodule

// File: rtl/rob_tq.sv
// One thread's in-order tag queue with its backward squash walker.
// Assumes: DEPTH is a power of two; the top never pushes into a full queue
// nor pops a non-ready head; no inserts arrive to a thread while it squashes.
module rob_tq #(
    parameter int DEPTH = 32,
    parameter int SW    = 16,
    parameter int SQW   = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     push,
    input  logic [SW-1:0]            push_seq,
    input  logic                     set_rdy,
    input  logic [SW-1:0]            set_seq,
    input  logic                     pop,
    input  logic                     sq_req,
    input  logic [SW-1:0]            sq_seq,
    output logic [$clog2(DEPTH):0]   cnt,
    output logic [SW-1:0]            head_seq,
    output logic [SW-1:0]            tail_seq,
    output logic                     head_rdy,
    output logic                     head_sqd,
    output logic                     sq_busy
);
    localparam int PW = $clog2(DEPTH);
    localparam int CW = PW + 1;

    logic [SW-1:0] seq_q [DEPTH];
    logic [DEPTH-1:0] rdy_q, sqd_q, occ, mark;
    logic [PW-1:0] rd_q, wr_q, walk_q, walk_n;
    logic [CW-1:0] cnt_q;
    logic [SW-1:0] sqn_q;
    logic          busy_q, busy_n;

    // Which slots currently hold a live entry
    always_comb begin
        for (int i = 0; i < DEPTH; i++)
            occ[i] = ({1'b0, PW'(i) - rd_q} < cnt_q);
    end

    // Squash step: visit up to SQW entries from the walk pointer toward the head
    always_comb begin
        logic run;
        mark   = '0;
        walk_n = walk_q;
        busy_n = busy_q && (cnt_q != '0);
        run    = busy_n;
        for (int k = 0; k < SQW; k++) begin
            if (run) begin
                if (seq_q[walk_n] <= sqn_q) begin
                    busy_n = 1'b0;
                    run    = 1'b0;
                end else begin
                    mark[walk_n] = 1'b1;
                    if (walk_n == rd_q) begin
                        busy_n = 1'b0;
                        run    = 1'b0;
                    end else begin
                        walk_n = walk_n - 1'b1;
                    end
                end
            end
        end
    end

    // Entry flags and stored sequence numbers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdy_q <= '0;
            sqd_q <= '0;
            for (int i = 0; i < DEPTH; i++) seq_q[i] <= '0;
        end else begin
            for (int i = 0; i < DEPTH; i++) begin
                if (set_rdy && occ[i] && seq_q[i] == set_seq) rdy_q[i] <= 1'b1;
                if (mark[i]) begin
                    rdy_q[i] <= 1'b1;
                    sqd_q[i] <= 1'b1;
                end
            end
            if (push) begin
                seq_q[wr_q] <= push_seq;
                rdy_q[wr_q] <= 1'b0;
                sqd_q[wr_q] <= 1'b0;
            end
        end
    end

    // Queue pointers and occupancy
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_q  <= '0;
            wr_q  <= '0;
            cnt_q <= '0;
        end else begin
            if (push) wr_q <= wr_q + 1'b1;
            if (pop)  rd_q <= rd_q + 1'b1;
            cnt_q <= cnt_q + CW'(push) - CW'(pop);
        end
    end

    // Squash walker state
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            walk_q <= '0;
            sqn_q  <= '0;
        end else if (sq_req && cnt_q != '0) begin
            busy_q <= 1'b1;
            walk_q <= wr_q - 1'b1;
            sqn_q  <= sq_seq;
        end else begin
            busy_q <= busy_n;
            walk_q <= busy_n ? walk_n : '0;
        end
    end

    assign cnt      = cnt_q;
    assign head_seq = seq_q[rd_q];
    assign tail_seq = seq_q[wr_q - 1'b1];
    assign head_rdy = (cnt_q != '0) && rdy_q[rd_q];
    assign head_sqd = (cnt_q != '0) && sqd_q[rd_q];
    assign sq_busy  = busy_q;
endmodule

// File: rtl/rob_age_pick.sv
// Picks the oldest head and youngest tail among threads flagged valid.
// Assumes: unsigned sequence compare, no wraparound; ties keep the lower thread.
module rob_age_pick #(
    parameter int NT = 4,
    parameter int SW = 16
) (
    input  logic [NT-1:0]            valid,
    input  logic [NT-1:0][SW-1:0]    heads,
    input  logic [NT-1:0][SW-1:0]    tails,
    output logic                     old_valid,
    output logic [$clog2(NT)-1:0]    old_tid,
    output logic [SW-1:0]            old_seq,
    output logic                     yng_valid,
    output logic [$clog2(NT)-1:0]    yng_tid,
    output logic [SW-1:0]            yng_seq
);
    localparam int TW = $clog2(NT);

    // Linear scan for minimum head and maximum tail
    always_comb begin
        old_valid = 1'b0;
        old_tid   = '0;
        old_seq   = '0;
        yng_valid = 1'b0;
        yng_tid   = '0;
        yng_seq   = '0;
        for (int t = 0; t < NT; t++) begin
            if (valid[t]) begin
                if (!old_valid || heads[t] < old_seq) begin
                    old_seq = heads[t];
                    old_tid = TW'(t);
                end
                if (!yng_valid || tails[t] > yng_seq) begin
                    yng_seq = tails[t];
                    yng_tid = TW'(t);
                end
                old_valid = 1'b1;
                yng_valid = 1'b1;
            end
        end
    end
endmodule

// File: rtl/rob_mt.sv
// Top of the shared multithreaded reorder buffer: per-thread queues,
// capacity limits, insert gating and global oldest/youngest selection.
// Assumes: at most one insert, one ready-set, one retire and one squash per cycle.
module rob_mt #(
    parameter int NT     = 4,
    parameter int DEPTH  = 32,
    parameter int SW     = 16,
    parameter int SQW    = 2,
    parameter int THRESH = 8
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic [1:0]                        policy,
    input  logic [$clog2(NT):0]               cfg_nthr,
    input  logic [NT-1:0]                     active,
    input  logic                              ins_valid,
    input  logic [$clog2(NT)-1:0]             ins_tid,
    input  logic [SW-1:0]                     ins_seq,
    output logic                              ins_ready,
    output logic                              ins_err,
    input  logic                              rdy_valid,
    input  logic [$clog2(NT)-1:0]             rdy_tid,
    input  logic [SW-1:0]                     rdy_seq,
    input  logic                              ret_valid,
    input  logic [$clog2(NT)-1:0]             ret_tid,
    input  logic                              sq_valid,
    input  logic [$clog2(NT)-1:0]             sq_tid,
    input  logic [SW-1:0]                     sq_seq,
    output logic [$clog2(DEPTH):0]            free_total,
    output logic [NT*($clog2(DEPTH)+1)-1:0]   free_thr,
    output logic                              head_valid,
    output logic [$clog2(NT)-1:0]             head_tid,
    output logic [SW-1:0]                     head_seq,
    output logic                              tail_valid,
    output logic [$clog2(NT)-1:0]             tail_tid,
    output logic [SW-1:0]                     tail_seq,
    output logic [NT-1:0]                     head_rdy,
    output logic [NT-1:0]                     head_sqd,
    output logic                              can_commit,
    output logic [NT-1:0]                     sq_busy
);
    localparam int CW = $clog2(DEPTH) + 1;

    logic [NT-1:0][CW-1:0] limit, cnt, fr;
    logic [NT-1:0][SW-1:0] hseq, tseq;
    logic [NT-1:0]         nonempty;
    logic [CW-1:0]         total;
    logic                  accept, err_q;

    rob_cap #(.NT(NT), .DEPTH(DEPTH), .THRESH(THRESH)) i_cap (
        .policy(policy), .cfg_nthr(cfg_nthr), .active(active), .limit(limit)
    );

    for (genvar t = 0; t < NT; t++) begin : g_thr
        rob_tq #(.DEPTH(DEPTH), .SW(SW), .SQW(SQW)) i_tq (
            .clk      (clk),
            .rst_n    (rst_n),
            .push     (accept && ins_tid == t),
            .push_seq (ins_seq),
            .set_rdy  (rdy_valid && rdy_tid == t),
            .set_seq  (rdy_seq),
            .pop      (ret_valid && ret_tid == t && head_rdy[t]),
            .sq_req   (sq_valid && sq_tid == t),
            .sq_seq   (sq_seq),
            .cnt      (cnt[t]),
            .head_seq (hseq[t]),
            .tail_seq (tseq[t]),
            .head_rdy (head_rdy[t]),
            .head_sqd (head_sqd[t]),
            .sq_busy  (sq_busy[t])
        );
        assign nonempty[t] = (cnt[t] != '0);
        assign fr[t] = (limit[t] > cnt[t]) ? limit[t] - cnt[t] : '0;
        assign free_thr[t*CW +: CW] = fr[t];
    end

    // Pool occupancy across all threads
    always_comb begin
        total = '0;
        for (int t = 0; t < NT; t++) total = total + cnt[t];
    end

    assign free_total = CW'(DEPTH) - total;
    assign ins_ready  = (total < CW'(DEPTH)) && (fr[ins_tid] != '0);
    assign accept     = ins_valid && ins_ready;
    assign can_commit = |(head_rdy & active);
    assign ins_err    = err_q;

    // Sticky flag for inserts offered while not ready
    always_ff @(posedge clk) begin
        if (!rst_n)                       err_q <= 1'b0;
        else if (ins_valid && !ins_ready) err_q <= 1'b1;
    end

    rob_age_pick #(.NT(NT), .SW(SW)) i_pick (
        .valid     (nonempty & active),
        .heads     (hseq),
        .tails     (tseq),
        .old_valid (head_valid),
        .old_tid   (head_tid),
        .old_seq   (head_seq),
        .yng_valid (tail_valid),
        .yng_tid   (tail_tid),
        .yng_seq   (tail_seq)
    );
endmodule

// File: rtl/rob_mt_chk.sv
// Property checker for rob_mt, attached through bind.
// Assumes: port names match the top module's.
module rob_mt_chk #(
    parameter int NT    = 4,
    parameter int DEPTH = 32
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      ins_valid,
    input logic                      ins_ready,
    input logic                      ins_err,
    input logic                      ret_valid,
    input logic [$clog2(DEPTH):0]    free_total,
    input logic                      head_valid,
    input logic                      tail_valid,
    input logic                      can_commit,
    input logic [NT-1:0]             head_rdy
);
    localparam int CW = $clog2(DEPTH) + 1;

    AST_FREE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        free_total <= CW'(DEPTH)); // R5
    AST_ACCEPT_TAKES_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        ins_valid && ins_ready && !ret_valid |=> free_total == $past(free_total) - 1'b1); // R5
    AST_REJECT_NO_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
        ins_valid && !ins_ready |=> free_total >= $past(free_total)); // R6
    AST_ERR_RAISED: assert property (@(posedge clk) disable iff (!rst_n)
        ins_valid && !ins_ready |=> ins_err); // R6
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        ins_err |=> ins_err); // R6
    AST_HEAD_TAIL_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
        head_valid == tail_valid); // R7
    AST_COMMIT_NEEDS_READY: assert property (@(posedge clk) disable iff (!rst_n)
        can_commit |-> (head_rdy != '0)); // R8
endmodule

bind rob_mt rob_mt_chk #(.NT(NT), .DEPTH(DEPTH)) i_chk (.*);

// File: tb/test_rob_mt.sv
// Directed bench for rob_mt: one task per scenario, each checking its own results.
module test_rob_mt;
    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [1:0]  policy;
    logic [2:0]  cfg_nthr;
    logic [3:0]  active;
    logic        ins_valid, rdy_valid, ret_valid, sq_valid;
    logic [1:0]  ins_tid, rdy_tid, ret_tid, sq_tid;
    logic [15:0] ins_seq, rdy_seq, sq_seq;
    logic        ins_ready, ins_err, head_valid, tail_valid, can_commit;
    logic [5:0]  free_total;
    logic [23:0] free_thr;
    logic [1:0]  head_tid, tail_tid;
    logic [15:0] head_seq, tail_seq;
    logic [3:0]  head_rdy, head_sqd, sq_busy;

    int total = 0;
    int bad   = 0;

    always #(CLK_P/2) clk = ~clk;

    rob_mt i_rob_mt (
        .clk(clk), .rst_n(rst_n), .policy(policy), .cfg_nthr(cfg_nthr), .active(active),
        .ins_valid(ins_valid), .ins_tid(ins_tid), .ins_seq(ins_seq),
        .ins_ready(ins_ready), .ins_err(ins_err),
        .rdy_valid(rdy_valid), .rdy_tid(rdy_tid), .rdy_seq(rdy_seq),
        .ret_valid(ret_valid), .ret_tid(ret_tid),
        .sq_valid(sq_valid), .sq_tid(sq_tid), .sq_seq(sq_seq),
        .free_total(free_total), .free_thr(free_thr),
        .head_valid(head_valid), .head_tid(head_tid), .head_seq(head_seq),
        .tail_valid(tail_valid), .tail_tid(tail_tid), .tail_seq(tail_seq),
        .head_rdy(head_rdy), .head_sqd(head_sqd), .can_commit(can_commit),
        .sq_busy(sq_busy)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic eq(input string req, input int act, input int exp);
        check(act == exp, req, act, exp);
    endtask

    function automatic int fthr(input int t);
        return int'(free_thr[t*6 +: 6]);
    endfunction

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        policy = 2'd0; cfg_nthr = 3'd4; active = 4'b1111;
        ins_valid = 0; rdy_valid = 0; ret_valid = 0; sq_valid = 0;
        ins_tid = 0; rdy_tid = 0; ret_tid = 0; sq_tid = 0;
        ins_seq = 0; rdy_seq = 0; sq_seq = 0;
        tick(); tick();
        rst_n = 1'b1;
        tick();
    endtask

    task automatic ins(input int tid, input int seq);
        ins_valid = 1; ins_tid = 2'(tid); ins_seq = 16'(seq);
        tick();
        ins_valid = 0;
    endtask

    task automatic mark_rdy(input int tid, input int seq);
        rdy_valid = 1; rdy_tid = 2'(tid); rdy_seq = 16'(seq);
        tick();
        rdy_valid = 0;
    endtask

    task automatic retire(input int tid);
        ret_valid = 1; ret_tid = 2'(tid);
        tick();
        ret_valid = 0;
    endtask

    task automatic t_reset();
        do_reset();
        eq("R1 free_total", free_total, 32);
        eq("R1 head_valid", head_valid, 0);
        eq("R1 tail_valid", tail_valid, 0);
        eq("R1 can_commit", can_commit, 0);
        eq("R1 sq_busy", sq_busy, 0);
        eq("R1 ins_err", ins_err, 0);
    endtask

    task automatic t_limits();
        do_reset();
        eq("R2 dyn thr3", fthr(3), 32);
        cfg_nthr = 3'd2; #1;
        eq("R2 dyn unconfigured thr2", fthr(2), 0);
        eq("R2 dyn configured thr1", fthr(1), 32);
        cfg_nthr = 3'd4; policy = 2'd1; #1;
        eq("R3 part 4 active", fthr(0), 8);
        active = 4'b0011; #1;
        eq("R3 part 2 active", fthr(1), 16);
        active = 4'b0000; #1;
        eq("R3 part none active", fthr(2), 8);
        active = 4'b1111; cfg_nthr = 3'd3; #1;
        eq("R3 part 3 configured", fthr(0), 10);
        eq("R2 part unconfigured thr3", fthr(3), 0);
        cfg_nthr = 3'd4; policy = 2'd2; #1;
        eq("R4 thresh cap", fthr(1), 8);
        active = 4'b0100; #1;
        eq("R4 thresh single active", fthr(2), 32);
        eq("R4 thresh other", fthr(0), 8);
    endtask

    task automatic t_head_tail();
        do_reset();
        ins(0, 10); ins(1, 5); ins(2, 20);
        eq("R5 free_total", free_total, 29);
        eq("R5 free_thr0", fthr(0), 31);
        eq("R7 head_seq", head_seq, 5);
        eq("R7 head_tid", head_tid, 1);
        eq("R7 tail_seq", tail_seq, 20);
        eq("R7 tail_tid", tail_tid, 2);
        active = 4'b1101; #1;
        eq("R7 head skips inactive", head_seq, 10);
        active = 4'b1111; #1;
        mark_rdy(0, 10);
        eq("R8 head_rdy0", head_rdy[0], 1);
        eq("R8 head_rdy1", head_rdy[1], 0);
        eq("R8 can_commit", can_commit, 1);
        active = 4'b1110; #1;
        eq("R8 can_commit inactive", can_commit, 0);
        active = 4'b1111; #1;
        retire(1);
        eq("R9 retire not ready ignored", free_total, 29);
        mark_rdy(1, 5);
        retire(1);
        eq("R9 retire frees", free_total, 30);
        eq("R9 new head", head_seq, 10);
        eq("R9 new head tid", head_tid, 0);
    endtask

    task automatic t_full_thread();
        do_reset();
        policy = 2'd2;
        for (int i = 0; i < 8; i++) ins(3, 100 + i);
        eq("R5 thread full free", fthr(3), 0);
        ins_tid = 2'd3; #1;
        eq("R6 ins_ready low", ins_ready, 0);
        ins(3, 200);
        eq("R6 rejected keeps count", free_total, 24);
        eq("R6 err set", ins_err, 1);
        ins(0, 1);
        eq("R6 other thread accepted", free_total, 23);
        eq("R6 err sticky", ins_err, 1);
    endtask

    task automatic t_squash_walk();
        do_reset();
        for (int i = 1; i <= 6; i++) ins(0, i);
        sq_valid = 1; sq_tid = 0; sq_seq = 16'd2;
        tick();
        sq_valid = 0;
        eq("R11 busy after request", sq_busy[0], 1);
        tick(); tick();
        eq("R11 busy while marking", sq_busy[0], 1);
        tick();
        eq("R12 done at boundary", sq_busy[0], 0);
        eq("R11 head not marked", head_sqd[0], 0);
        eq("R11 head not ready", head_rdy[0], 0);
        mark_rdy(0, 1); retire(0);
        eq("R11 boundary entry kept", head_sqd[0], 0);
        mark_rdy(0, 2); retire(0);
        eq("R11 younger squashed", head_sqd[0], 1);
        eq("R11 younger ready", head_rdy[0], 1);
        retire(0);
        eq("R11 drains by retire", free_total, 29);
    endtask

    task automatic t_squash_head();
        do_reset();
        ins(1, 10); ins(1, 11); ins(1, 12);
        sq_valid = 1; sq_tid = 1; sq_seq = 16'd0;
        tick();
        sq_valid = 0;
        tick();
        eq("R11 two per cycle", sq_busy[1], 1);
        tick();
        eq("R12 done at oldest", sq_busy[1], 0);
        eq("R12 oldest squashed", head_sqd[1], 1);
        eq("R12 oldest ready", head_rdy[1], 1);
        sq_valid = 1; sq_tid = 2; sq_seq = 16'd0;
        tick();
        sq_valid = 0;
        eq("R10 empty thread ignored", sq_busy[2], 0);
    endtask

    initial begin
        #(CLK_P * 100000);
        total++; bad++;
        $display("FAIL watchdog actual=0 expected=1");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        t_reset();
        t_limits();
        t_head_tail();
        t_full_thread();
        t_squash_walk();
        t_squash_head();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule